// File: doc/BRIEF.md
# Push-in first-out flow scheduler

This block is a hardware priority queue for packet scheduling. Each enqueued item carries a rank, a flow number and a logical queue number. Items leave only from the head of their logical queue, lowest rank first, while insertion lands wherever the rank places it. Several logical queues share one physical sorted array, and every sorted entry is tagged with its logical queue.

Only the oldest waiting item of each flow sits in the sorted flip-flop array. Later items of that flow wait in a small per-flow FIFO bank, the rank store. This relies on ranks not falling within a flow. When a dequeue removes a flow's head, the next item of that flow moves from its FIFO into the sorted array in the same cycle. One enqueue and one dequeue can be issued every clock cycle. Rank computation, payload storage and trees of such queues sit outside the block.

Top module: `pifo_flow_sched`

## Requirements
- R1: A dequeue on logical queue L removes the sorted-array entry of queue L with the lowest rank, and reports its rank and flow.
- R2: Entries of equal rank leave in the order they entered the sorted array. When a re-inserted entry and a new entry enter in the same cycle, the re-inserted one counts as earlier.
- R3: The sorted array holds at most one entry per flow. An enqueue for a flow that already has a sorted entry is appended to that flow's FIFO, and FIFO items keep their arrival order.
- R4: When a dequeue removes a flow's entry and that flow's FIFO is not empty, the oldest FIFO item enters the sorted array in the same cycle. A dequeue in the next cycle can select it.
- R5: An enqueue and a dequeue may be issued in the same cycle. If the dequeue removes the last item of the enqueued flow, the new item becomes that flow's sorted entry.
- R6: One cycle after a dequeue request, deq_done_o is 1. deq_hit_o is 1 if an entry was removed. If logical queue L held no sorted entry, deq_hit_o is 0 and deq_rank_o and deq_flow_o are 0.
- R7: A dequeue on one logical queue never removes or reorders entries of another logical queue.
- R8: An enqueue is rejected when its flow has a sorted entry, its FIFO already holds 4 items, and no dequeue removes that flow in the same cycle. enq_drop_o is then 1 in the next cycle, and the queue contents are left unchanged.
- R9: After reset all queues are empty and every output is 0.
- R10: A dequeue that removes a flow whose FIFO is full frees one FIFO slot in the same cycle. A concurrent enqueue to that flow is therefore accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Enqueue request |
| enq_lq_i | input | 1 | Logical queue of the enqueued item |
| enq_rank_i | input | 16 | Rank of the enqueued item |
| enq_flow_i | input | 3 | Flow of the enqueued item |
| enq_drop_o | output | 1 | Previous cycle's enqueue was rejected (FIFO full) |
| deq_valid_i | input | 1 | Dequeue request |
| deq_lq_i | input | 1 | Logical queue to dequeue from |
| deq_done_o | output | 1 | Response for the previous cycle's dequeue |
| deq_hit_o | output | 1 | An entry was removed |
| deq_rank_o | output | 16 | Rank of the removed entry, 0 on a miss |
| deq_flow_o | output | 3 | Flow of the removed entry, 0 on a miss |

## Verification
A corrupted sorted array or FIFO bank does not stay hidden for long. It shows as a wrong rank, a wrong flow or a wrong hit flag on the next dequeue that reaches the damaged entry. A lost FIFO count shows as a spurious or missing enq_drop_o one cycle after the next enqueue to that flow. Because the bench compares against its behavioural queue model on every cycle, a divergence is reported in the cycle its first effect reaches a port. Phases with narrow rank ranges, a single busy flow, and simultaneous pop and push stress the tie rule and the same-cycle paths.

// File: rtl/pifo_pkg.sv
package pifo_pkg;
  localparam int unsigned NUM_FLOWS  = 8;
  localparam int unsigned FIFO_DEPTH = 4;
  localparam int unsigned RANK_W     = 16;
  localparam int unsigned NUM_LQ     = 2;

  localparam int unsigned FLOW_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1;
  localparam int unsigned LQ_W   = (NUM_LQ > 1) ? $clog2(NUM_LQ) : 1;
  localparam int unsigned IDX_W  = FLOW_W;
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);

  typedef struct packed {
    logic              valid;
    logic [LQ_W-1:0]   lq;
    logic [FLOW_W-1:0] flow;
    logic [RANK_W-1:0] rank;
  } head_t;

  typedef struct packed {
    logic [LQ_W-1:0]   lq;
    logic [RANK_W-1:0] rank;
  } qent_t;
endpackage

// File: rtl/pifo_rank_store.sv
module pifo_rank_store
  import pifo_pkg::*;
#(
  parameter int unsigned FLOWS = NUM_FLOWS,
  parameter int unsigned DEPTH = FIFO_DEPTH
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  push_i,
  input  logic [$clog2(FLOWS)-1:0]              push_flow_i,
  input  qent_t                                 push_ent_i,
  input  logic                                  pop_i,
  input  logic [$clog2(FLOWS)-1:0]              pop_flow_i,
  output qent_t [FLOWS-1:0]                     head_o,
  output logic  [FLOWS-1:0][$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int unsigned FW = $clog2(FLOWS);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar f = 0; f < FLOWS; f++) begin : g_flow
    logic          wr_en, rd_en;
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    qent_t         mem_q [DEPTH];

    assign wr_en = push_i && (push_flow_i == FW'(f));
    assign rd_en = pop_i && (pop_flow_i == FW'(f));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q  <= '0;
        wr_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (wr_en) wr_q <= bump(wr_q);
        if (rd_en) rd_q <= bump(rd_q);
        cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_en) mem_q[wr_q] <= push_ent_i;
    end

    assign head_o[f] = mem_q[rd_q];
    assign cnt_o[f]  = cnt_q;

    assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(DEPTH));
    assert_full_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && cnt_q == CW'(DEPTH)) |-> rd_en);
    assert_pop_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en |-> (cnt_q != '0));
  end
endmodule

// File: rtl/pifo_remove.sv
module pifo_remove
  import pifo_pkg::*;
#(
  parameter int unsigned N = NUM_FLOWS
) (
  input  head_t [N-1:0]        arr_i,
  input  logic                 pop_i,
  input  logic [$clog2(N)-1:0] idx_i,
  output head_t [N-1:0]        arr_o
);
  localparam int unsigned IW = $clog2(N);

  // entries at and above the popped slot move one step toward the head
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic sh;
    assign sh = pop_i && (IW'(i) >= idx_i);
    if (i == N - 1) begin : g_last
      assign arr_o[i] = sh ? '0 : arr_i[i];
    end else begin : g_mid
      assign arr_o[i] = sh ? arr_i[i+1] : arr_i[i];
    end
  end
endmodule

// File: rtl/pifo_insert.sv
module pifo_insert
  import pifo_pkg::*;
#(
  parameter int unsigned N = NUM_FLOWS
) (
  input  head_t [N-1:0] arr_i,
  input  logic          en_i,
  input  head_t         ent_i,
  output head_t [N-1:0] arr_o
);
  // ge is a thermometer: sorted, packed array => first greater rank or first hole
  logic [N-1:0] ge;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign ge[i] = !arr_i[i].valid || (arr_i[i].rank > ent_i.rank);
    if (i == 0) begin : g_first
      assign arr_o[i] = (en_i && ge[i]) ? ent_i : arr_i[i];
    end else begin : g_rest
      assign arr_o[i] = (!en_i || !ge[i]) ? arr_i[i] :
                        (ge[i-1] ? arr_i[i-1] : ent_i);
    end
  end
endmodule

// File: rtl/pifo_flow_sched.sv
module pifo_flow_sched
  import pifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [LQ_W-1:0]   enq_lq_i,
  input  logic [RANK_W-1:0] enq_rank_i,
  input  logic [FLOW_W-1:0] enq_flow_i,
  output logic              enq_drop_o,
  input  logic              deq_valid_i,
  input  logic [LQ_W-1:0]   deq_lq_i,
  output logic              deq_done_o,
  output logic              deq_hit_o,
  output logic [RANK_W-1:0] deq_rank_o,
  output logic [FLOW_W-1:0] deq_flow_o
);
  head_t [NUM_FLOWS-1:0] arr_q, arr_rm, arr_ri, arr_d;
  qent_t [NUM_FLOWS-1:0] rs_head;
  logic  [NUM_FLOWS-1:0][CNT_W-1:0] rs_cnt;

  logic [NUM_FLOWS-1:0]                lq_match;
  logic [NUM_FLOWS-1:0][NUM_FLOWS-1:0] flow_hit;  // [flow][slot]
  logic [NUM_FLOWS-1:0]                has_head;

  logic              pop_hit;
  logic [IDX_W-1:0]  pop_idx;
  logic [FLOW_W-1:0] pop_flow;
  logic [RANK_W-1:0] pop_rank;

  logic  reins_en, popped_same, head_after, drop, to_fifo, to_arr;
  head_t reins_ent, new_ent;
  qent_t fifo_ent;

  // dequeue select: lowest slot whose logical queue matches
  for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_match
    assign lq_match[i] = arr_q[i].valid && (arr_q[i].lq == deq_lq_i);
  end

  always_comb begin
    pop_idx = '0;
    for (int i = NUM_FLOWS - 1; i >= 0; i--) begin
      if (lq_match[i]) pop_idx = IDX_W'(i);
    end
  end

  assign pop_hit  = deq_valid_i && (|lq_match);
  assign pop_flow = arr_q[pop_idx].flow;
  assign pop_rank = arr_q[pop_idx].rank;

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_slot
      assign flow_hit[f][i] = arr_q[i].valid && (arr_q[i].flow == FLOW_W'(f));
    end
    assign has_head[f] = |flow_hit[f];
  end

  // re-insert path: popped flow's next rank from its FIFO
  assign reins_en  = pop_hit && (rs_cnt[pop_flow] != '0);
  assign reins_ent = '{valid: 1'b1, lq: rs_head[pop_flow].lq,
                       flow: pop_flow, rank: rs_head[pop_flow].rank};

  // external enqueue path
  assign popped_same = pop_hit && (pop_flow == enq_flow_i);
  assign head_after  = has_head[enq_flow_i] &&
                       !(popped_same && rs_cnt[enq_flow_i] == '0);
  assign drop        = enq_valid_i && head_after && !popped_same &&
                       (rs_cnt[enq_flow_i] == CNT_W'(FIFO_DEPTH));
  assign to_fifo     = enq_valid_i && head_after && !drop;
  assign to_arr      = enq_valid_i && !head_after;
  assign new_ent     = '{valid: 1'b1, lq: enq_lq_i, flow: enq_flow_i, rank: enq_rank_i};
  assign fifo_ent    = '{lq: enq_lq_i, rank: enq_rank_i};

  pifo_rank_store #(.FLOWS(NUM_FLOWS), .DEPTH(FIFO_DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (to_fifo),
    .push_flow_i(enq_flow_i),
    .push_ent_i (fifo_ent),
    .pop_i      (reins_en),
    .pop_flow_i (pop_flow),
    .head_o     (rs_head),
    .cnt_o      (rs_cnt)
  );

  pifo_remove #(.N(NUM_FLOWS)) u_remove (
    .arr_i(arr_q),
    .pop_i(pop_hit),
    .idx_i(pop_idx),
    .arr_o(arr_rm)
  );

  // re-insert goes first so it wins ties against the new entry
  pifo_insert #(.N(NUM_FLOWS)) u_ins_reinsert (
    .arr_i(arr_rm),
    .en_i (reins_en),
    .ent_i(reins_ent),
    .arr_o(arr_ri)
  );

  pifo_insert #(.N(NUM_FLOWS)) u_ins_new (
    .arr_i(arr_ri),
    .en_i (to_arr),
    .ent_i(new_ent),
    .arr_o(arr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_q      <= '0;
      enq_drop_o <= 1'b0;
      deq_done_o <= 1'b0;
      deq_hit_o  <= 1'b0;
      deq_rank_o <= '0;
      deq_flow_o <= '0;
    end else begin
      arr_q      <= arr_d;
      enq_drop_o <= drop;
      deq_done_o <= deq_valid_i;
      deq_hit_o  <= pop_hit;
      deq_rank_o <= pop_hit ? pop_rank : '0;
      deq_flow_o <= pop_hit ? pop_flow : '0;
    end
  end

  for (genvar i = 0; i < NUM_FLOWS - 1; i++) begin : g_sorted_chk
    assert_sorted_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arr_q[i+1].valid |-> (arr_q[i].valid && arr_q[i].rank <= arr_q[i+1].rank));
  end

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow_chk
    assert_one_head_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(flow_hit[f]));
    assert_queued_has_head_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rs_cnt[f] != '0) |-> has_head[f]);
  end

  assert_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_i && !(|lq_match)) |=> (deq_done_o && !deq_hit_o));
  assert_reinsert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reins_en |=> has_head[$past(pop_flow)]);
  assert_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_arr |-> !arr_ri[NUM_FLOWS-1].valid);
endmodule

// File: tb/pifo_flow_sched_test.sv
module pifo_flow_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enq_valid_i = 1'b0;
  logic [0:0]  enq_lq_i = '0;
  logic [15:0] enq_rank_i = '0;
  logic [2:0]  enq_flow_i = '0;
  logic        enq_drop_o;
  logic        deq_valid_i = 1'b0;
  logic [0:0]  deq_lq_i = '0;
  logic        deq_done_o, deq_hit_o;
  logic [15:0] deq_rank_o;
  logic [2:0]  deq_flow_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pifo_flow_sched uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid_i), .enq_lq_i(enq_lq_i), .enq_rank_i(enq_rank_i),
    .enq_flow_i(enq_flow_i), .enq_drop_o(enq_drop_o),
    .deq_valid_i(deq_valid_i), .deq_lq_i(deq_lq_i),
    .deq_done_o(deq_done_o), .deq_hit_o(deq_hit_o),
    .deq_rank_o(deq_rank_o), .deq_flow_o(deq_flow_o)
  );

  typedef struct {int lq; int rank; int flow;} hent_t;
  hent_t heads[$];
  int    fq_r[NF][$];
  int    fq_l[NF][$];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int e_done = 0, e_hit = 0, e_rank = 0, e_flow = 0, e_drop = 0;

  task automatic chk(string req, string phase, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) %s actual=%0d expected=%0d", req, phase, what, act, exp);
    end
  endtask

  task automatic compare_all(string phase);
    chk("R6", phase, "deq_done", int'(deq_done_o), e_done);
    chk("R6", phase, "deq_hit",  int'(deq_hit_o),  e_hit);
    chk("R1", phase, "deq_rank", int'(deq_rank_o), e_rank);
    chk("R1", phase, "deq_flow", int'(deq_flow_o), e_flow);
    chk("R8", phase, "enq_drop", int'(enq_drop_o), e_drop);
  endtask

  // entries join after every entry of lower or equal rank (R2)
  task automatic ins_sorted(hent_t e);
    int pos = heads.size();
    for (int i = 0; i < heads.size(); i++) begin
      if (heads[i].rank > e.rank) begin
        pos = i;
        break;
      end
    end
    heads.insert(pos, e);
  endtask

  task automatic model_step(bit ev, int el, int er, int ef, bit dv, int dl);
    int idx = -1;
    bit has = 0;
    e_done = int'(dv); e_hit = 0; e_rank = 0; e_flow = 0; e_drop = 0;
    if (dv) begin
      for (int i = 0; i < heads.size(); i++) begin
        if (heads[i].lq == dl) begin
          idx = i;
          break;
        end
      end
      if (idx >= 0) begin
        hent_t h = heads[idx];
        heads.delete(idx);
        e_hit = 1; e_rank = h.rank; e_flow = h.flow;
        if (fq_r[h.flow].size() > 0) begin
          hent_t n;
          n.lq = fq_l[h.flow].pop_front();
          n.rank = fq_r[h.flow].pop_front();
          n.flow = h.flow;
          ins_sorted(n);
        end
      end
    end
    if (ev) begin
      for (int i = 0; i < heads.size(); i++) if (heads[i].flow == ef) has = 1;
      if (has) begin
        if (fq_r[ef].size() >= DEPTH) e_drop = 1;
        else begin
          fq_r[ef].push_back(er);
          fq_l[ef].push_back(el);
        end
      end else begin
        hent_t n;
        n.lq = el; n.rank = er; n.flow = ef;
        ins_sorted(n);
      end
    end
  endtask

  task automatic run_phase(string phase, int cycles, int enq_pct, int deq_pct,
                           int flow_max, int rank_max, bit fixed_lq);
    for (int c = 0; c < cycles; c++) begin
      bit ev, dv;
      int ef, el, er, dl;
      @(negedge clk);
      compare_all(phase);
      ev = ($urandom_range(0, 99) < enq_pct);
      dv = ($urandom_range(0, 99) < deq_pct);
      ef = $urandom_range(0, flow_max);
      el = fixed_lq ? (ef % 2) : $urandom_range(0, 1);
      er = $urandom_range(0, rank_max);
      dl = fixed_lq && flow_max == 0 ? 0 : $urandom_range(0, 1);
      model_step(ev, el, er, ef, dv, dl);
      enq_valid_i = ev;
      enq_lq_i    = el[0:0];
      enq_rank_i  = er[15:0];
      enq_flow_i  = ef[2:0];
      deq_valid_i = dv;
      deq_lq_i    = dl[0:0];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R9");  // reset: outputs all zero
    rst_ni = 1'b1;
    // R3/R8: fill two flows, overflow their FIFOs
    run_phase("R3", 16, 100, 0, 1, 40000, 1'b1);
    // R1/R6/R7: drain both logical queues, then misses on empty queues
    run_phase("R1", 24, 0, 100, 1, 0, 1'b1);
    // R4/R5/R10: one flow, push and pop every cycle with a full FIFO
    run_phase("R3", 6, 100, 0, 0, 100, 1'b1);
    run_phase("R4/R5/R10", 60, 100, 100, 0, 100, 1'b1);
    // R2: narrow ranks create many ties
    run_phase("R2", 600, 70, 50, 7, 2, 1'b1);
    // R7: mixed logical queues per flow, wide ranks
    run_phase("R7", 1500, 60, 55, 7, 65535, 1'b0);
    run_phase("R1", 200, 20, 90, 7, 9, 1'b1);
    @(negedge clk);
    compare_all("end");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule